// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is a byte-addressed timer peripheral. A 16-bit prescaler advances on every cycle of the 4.194304 MHz base clock. Its upper byte is readable as a free-running divider. An 8-bit count register advances at one of four rates taken from prescaler taps. When the count passes its maximum it is reloaded from a programmable modulo register instead of wrapping to zero, and a single-cycle interrupt request pulse is produced. The pulse is meant for bit 2 of an external interrupt flag register.

Software reaches four byte registers through one write strobe, a 2-bit register select and a combinational read port. The count advances on a falling edge of the selected prescaler tap gated by the enable bit. Because of this, reprogramming the rate or enable while the tap is high can add one extra step.

Top module: `prog_timer`

## Requirements
- R1: Register select 0 reads prescaler bits [15:8], which advance by one every 256 clock cycles.
- R2: Any write to register select 0 clears all 16 prescaler bits, whatever data is written.
- R3: With control bit 2 set, the count advances once per selected period. Rate code (control bits 1:0) 00 gives 1024 cycles, 01 gives 16 cycles, 10 gives 64 cycles and 11 gives 256 cycles, taken from prescaler bits 9, 3, 5 and 7.
- R4: With control bit 2 clear and the tap low, the count holds its value.
- R5: When the count is 8'hFF and a step occurs, it is loaded with the modulo register value.
- R6: Each such overflow drives irq_pulse high for exactly one cycle, in the cycle after the overflowing edge.
- R7: A write to register select 1 in the same cycle as an overflow loads the written data, suppresses the reload and produces no pulse.
- R8: A step is taken on a 1-to-0 transition of (selected tap AND enable), so clearing the enable while the tap is high adds one step.
- R9: Register select 1 is the count, 2 the modulo and 3 the control. Control reads back bits [2:0] with the upper bits as zero, and all registers reset to zero.
- R10: A modulo write in the same cycle as an overflow does not affect that reload, which uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.194304 MHz base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_pulse | output | 1 | One-cycle timer overflow request |

## Verification
Each of the four rate codes is run from a freshly cleared prescaler for four periods. This separates the tap mapping, because the codes do not encode the rates in rising order. Directed cases line up a count write, a modulo write and an enable clear with the exact cycle of a step. These show write priority, the old reload value and the extra falling-edge step. A long random mix of writes and reads to all four registers is compared each cycle against a cycle-level model of the requirements. This catches interactions such as a prescaler clear producing a step.

// File: rtl/tmr_pkg.sv
// Package: shared register select codes and the rate-code to tap mapping.
// Assumes the prescaler is at least 10 bits wide so every tap exists.
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_DIV = 2'd0,
        SEL_CNT = 2'd1,
        SEL_MOD = 2'd2,
        SEL_CTL = 2'd3
    } tmr_sel_e;

    localparam int CTL_W = 3;

    // Maps a rate code to the prescaler bit whose falling edge steps the count.
    function automatic int tap_index(input logic [1:0] rate);
        case (rate)
            2'd0:    return 9;
            2'd1:    return 3;
            2'd2:    return 5;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Module: free-running prescaler that advances every clock and clears on request.
// Assumes clr is a single-cycle strobe derived from a bus write.
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [DIV_W-1:0] div_q
);

    // Purpose: advance the prescaler, or clear it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_step_gen.sv
// Module: picks a prescaler tap by rate code, gates it with the enable bit and
// flags a step on each 1-to-0 transition of the gated tap.
// Assumes DIV_W covers the highest tap in tmr_pkg::tap_index.
module tmr_step_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic [1:0]       rate,
    input  logic             enable,
    output logic             step
);

    localparam int N_RATES = 4;

    logic [N_RATES-1:0] taps;
    logic               gated;
    logic               gated_q;

    // One tap per rate code, each taken from its own prescaler bit.
    for (genvar i = 0; i < N_RATES; i++) begin : g_tap
        localparam int TI = tmr_pkg::tap_index(2'(i));
        assign taps[i] = div_q[TI];
    end

    assign gated = taps[rate] & enable;

    // Purpose: remember the gated tap from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_q <= 1'b0;
        end else begin
            gated_q <= gated;
        end
    end

    assign step = gated_q & ~gated;

endmodule

// File: rtl/tmr_counter.sv
// Module: count register with modulo reload and a one-cycle overflow pulse.
// Assumes a bus load and a step may arrive together; the load then wins.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic overflow;

    assign overflow = step && !load_en && (count_q == CNT_MAX);

    // Purpose: load from the bus, reload on overflow, or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (overflow) begin
            count_q <= mod_val;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Purpose: register the overflow as a single-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= overflow;
        end
    end

endmodule

// File: rtl/prog_timer.sv
// Module: top of the timer. It decodes byte register accesses, holds the
// modulo and control registers and connects prescaler, step generator and counter.
// Assumes one access per cycle; reads are combinational on bus_addr.
module prog_timer #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_pulse
);

    import tmr_pkg::*;

    localparam int DIV_HI = DIV_W - 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] mod_q;
    logic [CTL_W-1:0] ctl_q;
    logic             wr_div;
    logic             wr_cnt;
    logic             step;

    assign wr_div = bus_wr && (bus_addr == SEL_DIV);
    assign wr_cnt = bus_wr && (bus_addr == SEL_CNT);

    // Purpose: hold the modulo and control registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            ctl_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == SEL_MOD) mod_q <= bus_wdata;
            if (bus_addr == SEL_CTL) ctl_q <= bus_wdata[CTL_W-1:0];
        end
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_div),
        .div_q (div_q)
    );

    tmr_step_gen #(.DIV_W(DIV_W)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_q  (div_q),
        .rate   (ctl_q[1:0]),
        .enable (ctl_q[2]),
        .step   (step)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load_en  (wr_cnt),
        .load_val (bus_wdata),
        .mod_val  (mod_q),
        .count_q  (count_q),
        .irq_q    (irq_pulse)
    );

    // Purpose: return the selected register on the read port.
    always_comb begin
        case (bus_addr)
            SEL_DIV: bus_rdata = div_q[DIV_HI -: CNT_W];
            SEL_CNT: bus_rdata = count_q;
            SEL_MOD: bus_rdata = mod_q;
            default: bus_rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
        endcase
    end

endmodule

// File: rtl/prog_timer_chk.sv
// Module: property checker for prog_timer, attached by bind.
module prog_timer_chk #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq_pulse,
    input logic [DIV_W-1:0] div_q,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] mod_q
);

    // R6
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7
    cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (!irq_pulse && count_q == $past(bus_wdata)));

    // R2
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (div_q == '0));

    // R1
    div_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> (div_q == $past(div_q) + 1'b1));

    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pulse) |-> (count_q == $past(mod_q)));

endmodule

bind prog_timer prog_timer_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_pulse (irq_pulse),
    .div_q     (div_q),
    .count_q   (count_q),
    .mod_q     (mod_q)
);

// File: tb/prog_timer_tb_top.sv
module prog_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Model state, from the requirements.
    logic [15:0] m_div = '0;
    logic        m_prev = 1'b0;
    logic [7:0]  m_cnt = '0;
    logic [7:0]  m_mod = '0;
    logic [2:0]  m_ctl = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    // R3 tap mapping: code 00 bit 9, 01 bit 3, 10 bit 5, 11 bit 7.
    function automatic logic gated_tap(input logic [2:0] ctl, input logic [15:0] dv);
        logic t;
        case (ctl[1:0])
            2'd0: t = dv[9];
            2'd1: t = dv[3];
            2'd2: t = dv[5];
            default: t = dv[7];
        endcase
        return t & ctl[2];
    endfunction

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_div[15:8];
            2'd1: return m_cnt;
            2'd2: return m_mod;
            default: return {5'd0, m_ctl};
        endcase
    endfunction

    function automatic logic step_next();
        return m_prev & ~gated_tap(m_ctl, m_div);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance the model across one edge using this cycle's bus inputs.
    task automatic model_edge();
        logic st;
        logic [7:0] old_mod;
        st = step_next();
        old_mod = m_mod;
        m_prev = gated_tap(m_ctl, m_div);
        m_irq = 1'b0;
        if (bus_wr && bus_addr == 2'd1) m_cnt = bus_wdata;
        else if (st && m_cnt == 8'hFF) begin
            m_cnt = old_mod;
            m_irq = 1'b1;
        end else if (st) m_cnt = m_cnt + 8'd1;
        if (bus_wr && bus_addr == 2'd0) m_div = '0;
        else m_div = m_div + 16'd1;
        if (bus_wr && bus_addr == 2'd2) m_mod = bus_wdata;
        if (bus_wr && bus_addr == 2'd3) m_ctl = bus_wdata[2:0];
    endtask

    // One bus cycle followed by a comparison against the model.
    task automatic cycle(input bit wr, input logic [1:0] a, input logic [7:0] d);
        string tag;
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            2'd0: tag = "R1";
            2'd1: tag = "R3";
            default: tag = "R9";
        endcase
        check(bus_rdata == model_read(a), tag, bus_rdata, model_read(a));
        check(irq_pulse == m_irq, "R6", irq_pulse, m_irq);
    endtask

    task automatic wait_step();
        int guard = 0;
        while (!step_next() && guard < 5000) begin
            cycle(1'b0, 2'd1, 8'd0);
            guard++;
        end
    endtask

    initial begin
        int period;
        logic [7:0] v;
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset values on every register
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            check(bus_rdata == 8'd0, "R9", bus_rdata, 0);
        end
        check(irq_pulse == 1'b0, "R6", irq_pulse, 0);
        rst_n = 1'b1;

        // R9 control keeps only bits 2:0
        cycle(1'b1, 2'd3, 8'hFA);
        check(bus_rdata == 8'h02, "R9", bus_rdata, 8'h02);

        // R2 divider clear, R1 upper byte steps every 256 cycles
        repeat (300) cycle(1'b0, 2'd0, 8'd0);
        cycle(1'b1, 2'd0, 8'h5A);
        check(bus_rdata == 8'd0, "R2", bus_rdata, 0);
        repeat (255) cycle(1'b0, 2'd0, 8'd0);
        check(bus_rdata == 8'd0, "R1", bus_rdata, 0);
        cycle(1'b0, 2'd0, 8'd0);
        check(bus_rdata == 8'd1, "R1", bus_rdata, 1);

        // R3 every rate code over four periods from a cleared prescaler
        for (int rc = 0; rc < 4; rc++) begin
            period = (rc == 0) ? 1024 : (rc == 1) ? 16 : (rc == 2) ? 64 : 256;
            cycle(1'b1, 2'd3, 8'(4 | rc));
            cycle(1'b1, 2'd0, 8'd0);
            cycle(1'b1, 2'd1, 8'd0);
            repeat (4 * period) cycle(1'b0, 2'd1, 8'd0);
            check(bus_rdata == 8'd4, "R3", bus_rdata, 4);
        end

        // R5 and R6 overflow reload with a pulse
        cycle(1'b1, 2'd3, 8'h05);
        cycle(1'b1, 2'd2, 8'h10);
        cycle(1'b1, 2'd1, 8'hFF);
        wait_step();
        cycle(1'b0, 2'd1, 8'd0);
        check(bus_rdata == 8'h10, "R5", bus_rdata, 8'h10);
        check(irq_pulse == 1'b1, "R6", irq_pulse, 1);
        cycle(1'b0, 2'd1, 8'd0);
        check(irq_pulse == 1'b0, "R6", irq_pulse, 0);

        // R7 count write collides with overflow
        cycle(1'b1, 2'd1, 8'hFF);
        wait_step();
        cycle(1'b1, 2'd1, 8'h33);
        check(bus_rdata == 8'h33, "R7", bus_rdata, 8'h33);
        check(irq_pulse == 1'b0, "R7", irq_pulse, 0);

        // R10 modulo write collides with overflow
        cycle(1'b1, 2'd1, 8'hFF);
        wait_step();
        cycle(1'b1, 2'd2, 8'h77);
        check(irq_pulse == 1'b1, "R10", irq_pulse, 1);
        cycle(1'b0, 2'd1, 8'd0);
        check(bus_rdata == 8'h10, "R10", bus_rdata, 8'h10);

        // R8 clearing enable while the tap is high adds one step
        cycle(1'b1, 2'd1, 8'h40);
        while (!gated_tap(m_ctl, m_div)) cycle(1'b0, 2'd1, 8'd0);
        v = m_cnt;
        cycle(1'b1, 2'd3, 8'h01);
        cycle(1'b0, 2'd1, 8'd0);
        check(bus_rdata == v + 8'd1, "R8", bus_rdata, v + 8'd1);

        // R4 disabled count holds
        repeat (300) cycle(1'b0, 2'd1, 8'd0);
        check(bus_rdata == v + 8'd1, "R4", bus_rdata, v + 8'd1);

        // Random mix against the model
        cycle(1'b1, 2'd3, 8'h05);
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cycle(r < 5, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule